// File: doc/BRIEF.md
# Video Raster Timing Generator with Front-Porch Prefetch

This block produces the raster timing for a video output: line sync, frame sync, a data-valid strobe and a one-cycle pulse that tells the fetch engine when to start pulling in the next frame. Software supplies a mode as boundary values for each direction: active size, sync start, sync end and total. The block turns these into sync-pulse, back-porch and front-porch widths. Each line is scanned in this order: sync pulse, back porch, active region, front porch. Frames are laid out the same way, so the front porch lines are the last lines of every frame.

When the mode is loaded, a calculator works out how many front-porch lines must be spent on early fetch. That number is whatever the start-of-frame blanking (vertical back porch plus vertical sync) cannot cover from a worst-case latency budget, set by parameter and 21 lines by default. The count is clamped to the front porch that exists, and a sticky warning is raised when the clamp applies. The line count is converted to a position on a pixel counter that spans the whole frame, and the fetch pulse fires at that position. When no prefetch is needed, the pulse fires on the first pixel of the frame instead. The border and underflow colour outputs are constants.

Top module: `vid_timing_gen`

## Requirements
- R1: Widths are derived per direction as sync width = sync_end − sync_start, back porch = total − sync_end and front porch = sync_start − active. The scan period in each direction is active + back porch + front porch + sync width. The vertical sync stays active for exactly vsync width × line period clocks per frame.
- R2: Every line runs as sync, back porch, active, front porch, and so does every frame. `de` is high only when both counters are inside their active region, giving active width × active height clocks of `de` per frame. A prefetch pulse never coincides with `de`.
- R3: A configuration latched with its negative-sync flag set makes that sync output active-low, and it then idles high. When `intf_is_dsi` was 1 at load, both syncs are active-high regardless of the flags.
- R4: If vertical back porch + vertical sync width ≥ the worst-case line budget, then `fetch_lines` = 0, `prefetch_en` = 0, `fetch_pos` = 0, and `fetch_start` fires on the first pixel of each frame.
- R5: Otherwise the needed line count is the budget minus (back porch + sync width). When the vertical front porch is at least this count, `fetch_lines` equals the needed count and no warning is raised.
- R6: When the vertical front porch is shorter than the needed count, `fetch_lines` equals the whole front porch and `low_porch_warn` goes to 1. It then stays at 1 until reset.
- R7: For a non-zero line count, `prefetch_en` = 1 and `fetch_pos` = (vertical total − fetch_lines) × horizontal total + 1. A frame counter is 1 on the frame's first pixel and steps by one each clock. `fetch_start` is a one-clock pulse on the clock where that counter equals `fetch_pos`.
- R8: `border_color` is always 0x00 and `underflow_color` is always 0xFF.
- R9: `cfg_load` is acted on only while `tg_enable` is 0. A load pulse while the generator runs changes no latched value.
- R10: While `tg_enable` is 0, `de` and `fetch_start` are 0 and both syncs sit at their inactive level. The first enabled clock is the first pixel of a frame, with both syncs active.
- R11: After reset, `prefetch_en`, `low_porch_warn`, `de` and `fetch_start` are 0 and both syncs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tg_enable | input | 1 | Run the counters; 0 holds them at the frame origin |
| cfg_load | input | 1 | Latch the mode inputs (honoured only while disabled) |
| h_active | input | W | Active pixels per line |
| h_sync_start | input | W | Horizontal sync start boundary |
| h_sync_end | input | W | Horizontal sync end boundary |
| h_total | input | W | Horizontal total boundary |
| v_active | input | W | Active lines per frame |
| v_sync_start | input | W | Vertical sync start boundary |
| v_sync_end | input | W | Vertical sync end boundary |
| v_total | input | W | Vertical total boundary |
| neg_hsync | input | 1 | Mode requests active-low line sync |
| neg_vsync | input | 1 | Mode requests active-low frame sync |
| intf_is_dsi | input | 1 | Interface is DSI; forces active-high syncs |
| hsync | output | 1 | Line sync at the latched polarity |
| vsync | output | 1 | Frame sync at the latched polarity |
| de | output | 1 | Data enable (active region) |
| fetch_start | output | 1 | One-clock start-of-fetch pulse |
| prefetch_en | output | 1 | Front-porch prefetch in use |
| fetch_lines | output | W | Front-porch lines given to prefetch |
| fetch_pos | output | 2W | Frame counter value of the prefetch pulse |
| low_porch_warn | output | 1 | Sticky: front porch was too short for the budget |
| border_color | output | 8 | Constant border colour |
| underflow_color | output | 8 | Constant underflow colour |

## Verification
With prefetch disabled, the fetch pulse lands on the same clock as the leading edge of both syncs at the frame origin. With prefetch enabled, it lands on the first pixel of a front-porch line, which must never coincide with the data enable. The bench provokes both cases by loading modes whose start-of-frame blanking is above, exactly at, and below the budget. It records the clock index of the pulse within a frame and compares it with the hand-computed position, and it flags any clock where the pulse and `de` are both high.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  // Outcome of the prefetch line calculation.
  typedef enum logic [1:0] {
    PF_OFF     = 2'd0,
    PF_EXACT   = 2'd1,
    PF_CLAMPED = 2'd2
  } pf_case_e;
endpackage

// File: rtl/vtg_mode_regs.sv
module vtg_mode_regs
  import vtg_pkg::*;
#(
  parameter int W        = 12,
  parameter int FW       = 2 * W,
  parameter int WC_LINES = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_ok,
  input  logic [W-1:0]  h_active,
  input  logic [W-1:0]  h_sync_start,
  input  logic [W-1:0]  h_sync_end,
  input  logic [W-1:0]  h_total,
  input  logic [W-1:0]  v_active,
  input  logic [W-1:0]  v_sync_start,
  input  logic [W-1:0]  v_sync_end,
  input  logic [W-1:0]  v_total,
  input  logic          neg_hsync,
  input  logic          neg_vsync,
  input  logic          intf_is_dsi,
  output logic [W-1:0]  h_pw_q,
  output logic [W-1:0]  h_bp_q,
  output logic [W-1:0]  h_act_q,
  output logic [W-1:0]  h_tot_q,
  output logic [W-1:0]  v_pw_q,
  output logic [W-1:0]  v_bp_q,
  output logic [W-1:0]  v_act_q,
  output logic [W-1:0]  v_tot_q,
  output logic [FW-1:0] frame_len_q,
  output logic          hs_low_q,
  output logic          vs_low_q,
  output logic [W-1:0]  pf_lines_q,
  output logic          pf_en_q,
  output logic [FW-1:0] pf_pos_q,
  output logic          warn_q,
  output pf_case_e      pf_case_q
);
  localparam logic [W:0] WC_L = (W+1)'(WC_LINES);

  // Span between two boundaries.
  function automatic logic [W-1:0] span(input logic [W-1:0] hi, input logic [W-1:0] lo);
    return hi - lo;
  endfunction

  // Scan period from its four parts.
  function automatic logic [W-1:0] period(input logic [W-1:0] act, input logic [W-1:0] bp,
                                          input logic [W-1:0] fp, input logic [W-1:0] pw);
    return act + bp + fp + pw;
  endfunction

  // Decide how the front porch is used for prefetch.
  function automatic pf_case_e classify(input logic [W-1:0] bp, input logic [W-1:0] pw,
                                        input logic [W-1:0] fp);
    logic [W:0] sof;
    logic [W:0] need;
    sof  = {1'b0, bp} + {1'b0, pw};
    need = WC_L - sof;
    if (sof >= WC_L)         return PF_OFF;
    else if ({1'b0, fp} < need) return PF_CLAMPED;
    else                     return PF_EXACT;
  endfunction

  // Frame counter value of the first pixel of line (vt - lines).
  function automatic logic [FW-1:0] fetch_point(input logic [W-1:0] vt, input logic [W-1:0] ht,
                                                input logic [W-1:0] lines);
    logic [FW-1:0] row;
    row = FW'(vt - lines);
    return row * FW'(ht) + FW'(1);
  endfunction

  logic [W-1:0]  d_hbp, d_hfp, d_hpw, d_ht;
  logic [W-1:0]  d_vbp, d_vfp, d_vpw, d_vt;
  logic [W:0]    d_sof;
  logic [W-1:0]  d_lines;
  logic [FW-1:0] d_pos;
  pf_case_e      d_case;

  always_comb begin
    d_hbp  = span(h_total, h_sync_end);
    d_hfp  = span(h_sync_start, h_active);
    d_hpw  = span(h_sync_end, h_sync_start);
    d_vbp  = span(v_total, v_sync_end);
    d_vfp  = span(v_sync_start, v_active);
    d_vpw  = span(v_sync_end, v_sync_start);
    d_ht   = period(h_active, d_hbp, d_hfp, d_hpw);
    d_vt   = period(v_active, d_vbp, d_vfp, d_vpw);
    d_sof  = {1'b0, d_vbp} + {1'b0, d_vpw};
    d_case = classify(d_vbp, d_vpw, d_vfp);
    unique case (d_case)
      PF_EXACT:   d_lines = W'(WC_L - d_sof);
      PF_CLAMPED: d_lines = d_vfp;
      default:    d_lines = '0;
    endcase
    d_pos = (d_lines != '0) ? fetch_point(d_vt, d_ht, d_lines) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_pw_q      <= '0;
      h_bp_q      <= '0;
      h_act_q     <= '0;
      h_tot_q     <= W'(1);
      v_pw_q      <= '0;
      v_bp_q      <= '0;
      v_act_q     <= '0;
      v_tot_q     <= W'(1);
      frame_len_q <= FW'(1);
      hs_low_q    <= 1'b0;
      vs_low_q    <= 1'b0;
      pf_lines_q  <= '0;
      pf_en_q     <= 1'b0;
      pf_pos_q    <= '0;
      pf_case_q   <= PF_OFF;
    end else if (load_ok) begin
      h_pw_q      <= d_hpw;
      h_bp_q      <= d_hbp;
      h_act_q     <= h_active;
      h_tot_q     <= d_ht;
      v_pw_q      <= d_vpw;
      v_bp_q      <= d_vbp;
      v_act_q     <= v_active;
      v_tot_q     <= d_vt;
      frame_len_q <= FW'(d_vt) * FW'(d_ht);
      hs_low_q    <= neg_hsync & ~intf_is_dsi;
      vs_low_q    <= neg_vsync & ~intf_is_dsi;
      pf_lines_q  <= d_lines;
      pf_en_q     <= (d_lines != '0);
      pf_pos_q    <= d_pos;
      pf_case_q   <= d_case;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               warn_q <= 1'b0;
    else if (load_ok && d_case == PF_CLAMPED) warn_q <= 1'b1;
  end
endmodule

// File: rtl/vtg_scan_counters.sv
module vtg_scan_counters #(
  parameter int W  = 12,
  parameter int FW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [W-1:0]  h_tot,
  input  logic [W-1:0]  v_tot,
  input  logic [FW-1:0] frame_len,
  output logic [W-1:0]  hcnt,
  output logic [W-1:0]  vcnt,
  output logic [FW-1:0] fcnt,
  output logic          line_end,
  output logic          frame_end
);
  assign line_end  = (hcnt == h_tot - W'(1));
  assign frame_end = line_end && (vcnt == v_tot - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (!run) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= frame_end ? '0 : vcnt + W'(1);
    end else begin
      hcnt <= hcnt + W'(1);
    end
  end

  // Frame-wide pixel counter: 1 on the first pixel, wraps after frame_len.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  fcnt <= FW'(1);
    else if (!run)               fcnt <= FW'(1);
    else if (fcnt >= frame_len)  fcnt <= FW'(1);
    else                         fcnt <= fcnt + FW'(1);
  end
endmodule

// File: rtl/vtg_sync_decode.sv
module vtg_sync_decode #(
  parameter int W  = 12,
  parameter int FW = 2 * W
) (
  input  logic          run,
  input  logic [W-1:0]  hcnt,
  input  logic [W-1:0]  vcnt,
  input  logic [FW-1:0] fcnt,
  input  logic [W-1:0]  h_pw,
  input  logic [W-1:0]  h_bp,
  input  logic [W-1:0]  h_act,
  input  logic [W-1:0]  v_pw,
  input  logic [W-1:0]  v_bp,
  input  logic [W-1:0]  v_act,
  input  logic          hs_low,
  input  logic          vs_low,
  input  logic          pf_en,
  input  logic [FW-1:0] pf_pos,
  output logic          h_in_sync,
  output logic          v_in_sync,
  output logic          h_in_act,
  output logic          v_in_act,
  output logic          fetch_hit,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          fetch_start
);
  localparam int XW = W + 2;

  function automatic logic [XW-1:0] ext(input logic [W-1:0] x);
    return {2'b00, x};
  endfunction

  // Inside [pw+bp, pw+bp+act) on a counter.
  function automatic logic in_active(input logic [W-1:0] c, input logic [W-1:0] pw,
                                     input logic [W-1:0] bp, input logic [W-1:0] act);
    logic [XW-1:0] lo;
    lo = ext(pw) + ext(bp);
    return (ext(c) >= lo) && (ext(c) < lo + ext(act));
  endfunction

  assign h_in_sync = (hcnt < h_pw);
  assign v_in_sync = (vcnt < v_pw);
  assign h_in_act  = in_active(hcnt, h_pw, h_bp, h_act);
  assign v_in_act  = in_active(vcnt, v_pw, v_bp, v_act);
  assign fetch_hit = pf_en ? (fcnt == pf_pos) : (fcnt == FW'(1));

  assign hsync       = (run & h_in_sync) ^ hs_low;
  assign vsync       = (run & v_in_sync) ^ vs_low;
  assign de          = run & h_in_act & v_in_act;
  assign fetch_start = run & fetch_hit;
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vtg_pkg::*;
#(
  parameter int W        = 12,
  parameter int WC_LINES = 21,
  parameter int CW       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tg_enable,
  input  logic            cfg_load,
  input  logic [W-1:0]    h_active,
  input  logic [W-1:0]    h_sync_start,
  input  logic [W-1:0]    h_sync_end,
  input  logic [W-1:0]    h_total,
  input  logic [W-1:0]    v_active,
  input  logic [W-1:0]    v_sync_start,
  input  logic [W-1:0]    v_sync_end,
  input  logic [W-1:0]    v_total,
  input  logic            neg_hsync,
  input  logic            neg_vsync,
  input  logic            intf_is_dsi,
  output logic            hsync,
  output logic            vsync,
  output logic            de,
  output logic            fetch_start,
  output logic            prefetch_en,
  output logic [W-1:0]    fetch_lines,
  output logic [2*W-1:0]  fetch_pos,
  output logic            low_porch_warn,
  output logic [CW-1:0]   border_color,
  output logic [CW-1:0]   underflow_color
);
  localparam int FW = 2 * W;

  logic          load_ok;
  logic [W-1:0]  h_pw, h_bp, h_act, h_tot;
  logic [W-1:0]  v_pw, v_bp, v_act, v_tot;
  logic [FW-1:0] frame_len;
  logic          hs_low, vs_low;
  pf_case_e      pf_case;
  logic [W-1:0]  hcnt, vcnt;
  logic [FW-1:0] fcnt;
  logic          line_end, frame_end;
  logic          h_in_sync, v_in_sync, h_in_act, v_in_act, fetch_hit;

  assign load_ok = cfg_load & ~tg_enable;

  vtg_mode_regs #(.W(W), .FW(FW), .WC_LINES(WC_LINES)) mode_i (
    .clk(clk), .rst_n(rst_n), .load_ok(load_ok),
    .h_active(h_active), .h_sync_start(h_sync_start), .h_sync_end(h_sync_end), .h_total(h_total),
    .v_active(v_active), .v_sync_start(v_sync_start), .v_sync_end(v_sync_end), .v_total(v_total),
    .neg_hsync(neg_hsync), .neg_vsync(neg_vsync), .intf_is_dsi(intf_is_dsi),
    .h_pw_q(h_pw), .h_bp_q(h_bp), .h_act_q(h_act), .h_tot_q(h_tot),
    .v_pw_q(v_pw), .v_bp_q(v_bp), .v_act_q(v_act), .v_tot_q(v_tot),
    .frame_len_q(frame_len), .hs_low_q(hs_low), .vs_low_q(vs_low),
    .pf_lines_q(fetch_lines), .pf_en_q(prefetch_en), .pf_pos_q(fetch_pos),
    .warn_q(low_porch_warn), .pf_case_q(pf_case)
  );

  vtg_scan_counters #(.W(W), .FW(FW)) cnt_i (
    .clk(clk), .rst_n(rst_n), .run(tg_enable),
    .h_tot(h_tot), .v_tot(v_tot), .frame_len(frame_len),
    .hcnt(hcnt), .vcnt(vcnt), .fcnt(fcnt),
    .line_end(line_end), .frame_end(frame_end)
  );

  vtg_sync_decode #(.W(W), .FW(FW)) dec_i (
    .run(tg_enable), .hcnt(hcnt), .vcnt(vcnt), .fcnt(fcnt),
    .h_pw(h_pw), .h_bp(h_bp), .h_act(h_act),
    .v_pw(v_pw), .v_bp(v_bp), .v_act(v_act),
    .hs_low(hs_low), .vs_low(vs_low),
    .pf_en(prefetch_en), .pf_pos(fetch_pos),
    .h_in_sync(h_in_sync), .v_in_sync(v_in_sync),
    .h_in_act(h_in_act), .v_in_act(v_in_act), .fetch_hit(fetch_hit),
    .hsync(hsync), .vsync(vsync), .de(de), .fetch_start(fetch_start)
  );

  assign border_color    = '0;
  assign underflow_color = {CW{1'b1}};
endmodule

// File: rtl/vid_timing_gen_chk.sv
module vid_timing_gen_chk #(
  parameter int W  = 12,
  parameter int FW = 2 * W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tg_enable,
  input logic          de,
  input logic          fetch_start,
  input logic          prefetch_en,
  input logic          low_porch_warn,
  input logic [W-1:0]  hcnt,
  input logic [W-1:0]  vcnt,
  input logic [FW-1:0] fcnt,
  input logic [FW-1:0] frame_len,
  input logic          v_in_act
);
  // R7
  fetch_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_start && frame_len > FW'(1)) |=> !fetch_start);

  // R2
  fetch_not_in_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_start && prefetch_en) |-> (!de && !v_in_act));

  // R6
  warn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_porch_warn |=> low_porch_warn);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tg_enable |-> (!de && !fetch_start));

  // R7
  frame_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tg_enable && hcnt == '0 && vcnt == '0) |-> (fcnt == FW'(1)));

  // R10
  enable_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tg_enable) |-> (hcnt == '0 && vcnt == '0 && fcnt == FW'(1)));
endmodule

bind vid_timing_gen vid_timing_gen_chk #(.W(W), .FW(2 * W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tg_enable(tg_enable), .de(de),
  .fetch_start(fetch_start), .prefetch_en(prefetch_en),
  .low_porch_warn(low_porch_warn), .hcnt(hcnt), .vcnt(vcnt),
  .fcnt(fcnt), .frame_len(frame_len), .v_in_act(v_in_act)
);

// File: tb/vid_timing_gen_tb_top.sv
module vid_timing_gen_tb_top;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tg_enable = 1'b0, cfg_load = 1'b0;
  logic [W-1:0] h_active = '0, h_sync_start = '0, h_sync_end = '0, h_total = '0;
  logic [W-1:0] v_active = '0, v_sync_start = '0, v_sync_end = '0, v_total = '0;
  logic neg_hsync = 1'b0, neg_vsync = 1'b0, intf_is_dsi = 1'b0;
  logic hsync, vsync, de, fetch_start, prefetch_en, low_porch_warn;
  logic [W-1:0] fetch_lines;
  logic [2*W-1:0] fetch_pos;
  logic [7:0] border_color, underflow_color;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  vid_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .tg_enable(tg_enable), .cfg_load(cfg_load),
    .h_active(h_active), .h_sync_start(h_sync_start), .h_sync_end(h_sync_end), .h_total(h_total),
    .v_active(v_active), .v_sync_start(v_sync_start), .v_sync_end(v_sync_end), .v_total(v_total),
    .neg_hsync(neg_hsync), .neg_vsync(neg_vsync), .intf_is_dsi(intf_is_dsi),
    .hsync(hsync), .vsync(vsync), .de(de), .fetch_start(fetch_start),
    .prefetch_en(prefetch_en), .fetch_lines(fetch_lines), .fetch_pos(fetch_pos),
    .low_porch_warn(low_porch_warn), .border_color(border_color),
    .underflow_color(underflow_color)
  );

  // Horizontal mode for the table: active 4, sync 6..7, total 10 -> fp 2, pw 1, bp 3, period 10.
  // Columns: v_active, v_sync_start, v_sync_end, v_total, lines, prefetch_en, fetch_pos, warn.
  localparam int NV = 6;
  localparam int VEC [NV][8] = '{
    '{4, 24, 26, 30, 15, 1, 151, 0},  // R5 room in porch
    '{4,  5,  7, 30,  0, 0,   0, 0},  // R4 blanking above budget
    '{4,  6,  8, 27,  0, 0,   0, 0},  // R4 blanking exactly at budget
    '{4,  5,  7, 25,  1, 1, 241, 0},  // R5 porch exactly the need
    '{4, 14, 16, 20, 10, 1, 101, 1},  // R6 clamped to porch
    '{4,  4,  6, 10,  0, 0,   0, 1}   // R6 no porch, warning stays
  };

  task automatic check_eq(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_mode(input int ha, input int hs, input int he, input int ht,
                           input int va, input int vs, input int ve, input int vt,
                           input bit nh, input bit nv, input bit dsi);
    @(negedge clk);
    h_active = W'(ha); h_sync_start = W'(hs); h_sync_end = W'(he); h_total = W'(ht);
    v_active = W'(va); v_sync_start = W'(vs); v_sync_end = W'(ve); v_total = W'(vt);
    neg_hsync = nh; neg_vsync = nv; intf_is_dsi = dsi;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int fetch_at, de_cnt, vs_cnt, overlap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state, R8 constants
    check_eq("R11 prefetch_en", prefetch_en, 0);
    check_eq("R11 warn", low_porch_warn, 0);
    check_eq("R11 de", de, 0);
    check_eq("R11 fetch_start", fetch_start, 0);
    check_eq("R11 hsync", hsync, 0);
    check_eq("R11 vsync", vsync, 0);
    check_eq("R8 border", border_color, 8'h00);
    check_eq("R8 underflow", underflow_color, 8'hFF);

    // Table walk: R1 R2 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      int nclk;
      load_mode(4, 6, 7, 10, VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 0, 0, 0);
      check_eq("R4/R5/R6 fetch_lines", fetch_lines, VEC[i][4]);
      check_eq("R4/R7 prefetch_en", prefetch_en, VEC[i][5]);
      check_eq("R7 fetch_pos", fetch_pos, VEC[i][6]);
      check_eq("R6 low_porch_warn", low_porch_warn, VEC[i][7]);
      nclk = VEC[i][3] * 10;
      fetch_at = 0; de_cnt = 0; vs_cnt = 0; overlap = 0;
      tg_enable = 1'b1;
      for (int c = 1; c <= nclk; c++) begin
        #1;
        if (fetch_start && fetch_at == 0) fetch_at = c;
        if (de) de_cnt++;
        if (vsync) vs_cnt++;
        if (fetch_start && de) overlap++;
        @(negedge clk);
      end
      tg_enable = 1'b0;
      check_eq("R7/R4 fetch clock", fetch_at, (VEC[i][5] != 0) ? VEC[i][6] : 1);
      check_eq("R2 de count", de_cnt, 16);
      check_eq("R1 vsync clocks", vs_cnt, (VEC[i][2] - VEC[i][1]) * 10);
      check_eq("R2 fetch with de", overlap, 0);
    end

    // R6 warning remains after a non-clamping load
    load_mode(4, 6, 7, 10, 4, 24, 26, 30, 0, 0, 0);
    check_eq("R6 sticky warn", low_porch_warn, 1);

    // R1 line period and hsync width, R10 first clock is frame origin
    tg_enable = 1'b1;
    #1;
    check_eq("R10 first hsync", hsync, 1);
    check_eq("R10 first vsync", vsync, 1);
    @(negedge clk); #1;
    check_eq("R1 hsync width", hsync, 0);
    for (int c = 3; c <= 11; c++) begin @(negedge clk); #1; end
    check_eq("R1 line period", hsync, 1);

    // R9 load while running is ignored
    @(negedge clk);
    h_active = 12'd4; h_sync_start = 12'd6; h_sync_end = 12'd7; h_total = 12'd10;
    v_active = 12'd4; v_sync_start = 12'd5; v_sync_end = 12'd7; v_total = 12'd30;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    tg_enable = 1'b0;
    @(negedge clk); #1;
    check_eq("R9 fetch_pos kept", fetch_pos, 151);
    check_eq("R9 fetch_lines kept", fetch_lines, 15);
    check_eq("R10 idle de", de, 0);
    check_eq("R10 idle hsync", hsync, 0);

    // R3 active-low syncs on a non-DSI interface
    load_mode(4, 6, 7, 10, 4, 24, 26, 30, 1, 1, 0);
    check_eq("R3 idle hsync high", hsync, 1);
    check_eq("R3 idle vsync high", vsync, 1);
    tg_enable = 1'b1; #1;
    check_eq("R3 active-low hsync", hsync, 0);
    check_eq("R3 active-low vsync", vsync, 0);
    @(negedge clk); tg_enable = 1'b0;

    // R3 DSI forces active-high
    load_mode(4, 6, 7, 10, 4, 24, 26, 30, 1, 1, 1);
    check_eq("R3 dsi idle hsync", hsync, 0);
    tg_enable = 1'b1; #1;
    check_eq("R3 dsi hsync", hsync, 1);
    check_eq("R3 dsi vsync", vsync, 1);
    @(negedge clk); tg_enable = 1'b0;
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule